// File: doc/BRIEF.md
# Timed compare pulse output

This peripheral places an edge on an output pin at a precise instant of a free-running 64-bit time base. Software programs a 64-bit target time as two 32-bit words. It selects one of several edge actions and enables the block. When the time base reaches the target, the block applies the action to the pin, counts the event, and disarms itself. The time base arrives as an input and is sampled in the block's own clock domain.

The target time is staged. The high word is written first and is held aside. Writing the low word then loads the full 64-bit value in one step and arms the block, so a half-written value can never produce a match. A target of zero means nothing is armed. The pin edge lags the matching time sample by two clocks, and software compensates for this in the target it loads. The event counter lets software detect a missed pulse: if the count has not moved since the previous read, no edge was produced.

Top module: `timed_pulse_gen`

## Requirements
- R1: After reset the pin is low, the pin output-enable is high, and the control, compare-low, compare-high and event-count registers all read zero.
- R2: Registers sit at byte offsets 0x00 (control), 0x10 (compare low word), 0x14 (compare high word) and 0x30 (event count). Control bit 0 is the enable, bit 1 is the direction, and bits 3:2 are the edge action. Unused control bits and unmapped offsets read as zero.
- R3: The pin output-enable is high when control bit 1 is 0 and low when it is 1.
- R4: A high-word write only stages a value, and reads of 0x14 still return the active high word. A low-word write loads {staged high, written low} as the active compare value and arms the block.
- R5: A low-word write that makes the active compare value zero leaves the block disarmed, and no edge or count follows.
- R6: The block matches when the sampled time is greater than or equal to the active compare value. If time value T is the first matching sample, the pin changes on the second clock edge after the edge that sampled T. A target already in the past matches on the first sample after arming or enabling.
- R7: On a match, edge action 0 drives the pin high, 1 drives it low and 2 inverts it, and the event count increases by exactly one. Action 3 leaves both the pin and the count unchanged.
- R8: While the enable is clear, the pin holds its level, no match is detected, and the event count does not change. A pending compare stays armed and fires once the enable is set again.
- R9: Each arming produces at most one edge. After it fires, the block stays disarmed until the next low-word write.
- R10: The bus is always ready. A read returns its data with the response valid one clock after the request. Writes to the event-count offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the time base advances in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | 64 | Free-running time base |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Read data valid, one clock after a read request |
| rsp_rdata | output | 32 | Read data |
| pin_out | output | 1 | Driven pin level |
| pin_oe | output | 1 | Pin output-enable (high = drive) |

## Verification
The assertions check on every cycle that the pin and the event count are frozen while the block is disabled, that the count never moves by more than one, that an armed state always holds a nonzero compare value, that a fired compare leaves the block disarmed unless a reload arrived on the same edge, and that read responses arrive one clock after the request. The exact clock on which an edge appears, the level that each edge action produces, the protection given by the staged high word, and the behaviour of past targets can only be shown by the bench's scenarios. The bench sweeps every edge action against past, near and later targets and predicts each edge time from the sampled time base.

// File: rtl/tpg_pkg.sv
// Package: shared offsets and types for the timed compare pulse output.
// Assumes byte addressing of 32-bit registers.
package tpg_pkg;

    localparam int unsigned OFS_CTRL   = 'h00;
    localparam int unsigned OFS_CMP_LO = 'h10;
    localparam int unsigned OFS_CMP_HI = 'h14;
    localparam int unsigned OFS_EVT    = 'h30;

    // Edge action applied to the pin on a match
    typedef enum logic [1:0] {
        EDGE_RISE   = 2'd0,
        EDGE_FALL   = 2'd1,
        EDGE_TOGGLE = 2'd2,
        EDGE_NONE   = 2'd3
    } edge_mode_e;

    // Control register layout: [3:2] mode, [1] direction (1 = input), [0] enable
    typedef struct packed {
        edge_mode_e mode;
        logic       dir_in;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tpg_regs.sv
// Module: register file and bus front end.
// Holds the control register and the staged high compare word. It produces
// the compare-load strobe on a low-word write. Reads are registered and
// answered one clock after the request. The bus is always ready.
// Assumes the compare value is exactly two data words wide.
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    input  logic [2*DATA_W-1:0]   cmp_q,
    input  logic [DATA_W-1:0]     evt_count,
    output ctrl_t                 ctrl_q,
    output logic                  load_stb,
    output logic [2*DATA_W-1:0]   load_val
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_CMP_LO);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_CMP_HI);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);

    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] hi_stage_q;
    logic [DATA_W-1:0] rd_mux;

    assign req_ready = 1'b1;
    assign wr_en     = req_valid && req_write;
    assign rd_en     = req_valid && !req_write;
    assign load_stb  = wr_en && (req_addr == A_LO);
    assign load_val  = {hi_stage_q, req_wdata};

    // Control register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && (req_addr == A_CTRL)) begin
            ctrl_q <= ctrl_t'(req_wdata[CTRL_W-1:0]);
        end
    end

    // Staged high compare word, taken up only by the next low-word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage_q <= '0;
        end else if (wr_en && (req_addr == A_HI)) begin
            hi_stage_q <= req_wdata;
        end
    end

    // Read data selection; reserved bits and unmapped offsets give zero
    always_comb begin
        rd_mux = '0;
        case (req_addr)
            A_CTRL:  rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            A_LO:    rd_mux = cmp_q[DATA_W-1:0];
            A_HI:    rd_mux = cmp_q[2*DATA_W-1:DATA_W];
            A_EVT:   rd_mux = evt_count;
            default: rd_mux = '0;
        endcase
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                rsp_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/tpg_match.sv
// Module: compare, arming and delay pipeline.
// Holds the active compare value and the armed flag. A match is a sampled
// time greater than or equal to the compare value, taken while the block is
// armed and enabled. A match disarms the block and travels down a DELAY-stage
// pipeline, so the pin stage acts DELAY edges after the matching sample.
// A reload on the same edge as a match takes priority. Assumes DELAY >= 1.
module tpg_match #(
    parameter int TIME_W = 64,
    parameter int DELAY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TIME_W-1:0] time_now,
    input  logic              load_stb,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] cmp_q,
    output logic              armed_q,
    output logic              hit_q,
    output logic              fire
);

    logic             hit;
    logic [DELAY-1:0] pipe_q;

    assign hit = en && armed_q && (time_now >= cmp_q);

    // Active compare value, loaded as a whole on the low-word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (load_stb) begin
            cmp_q <= load_val;
        end
    end

    // Arm on a nonzero load and disarm after one match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (load_stb) begin
            armed_q <= (load_val != '0);
        end else if (hit) begin
            armed_q <= 1'b0;
        end
    end

    // Match delay pipeline, shaped by DELAY
    generate
        if (DELAY == 1) begin : g_single
            // One stage: the registered match drives the pin stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= hit;
            end
        end else begin : g_multi
            // Several stages: shift the match toward the pin stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[DELAY-2:0], hit};
            end
        end
    endgenerate

    assign hit_q = pipe_q[0];
    assign fire  = pipe_q[DELAY-1];

endmodule

// File: rtl/tpg_pin.sv
// Module: pin driver and event counter.
// Applies the selected edge action when a delayed match arrives while
// enabled, and counts each action that is applied. Action 3 is inert. The
// pin resets low, and the counter wraps at its width.
module tpg_pin
    import tpg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fire,
    input  edge_mode_e       mode,
    output logic             pin_q,
    output logic [CNT_W-1:0] evt_q
);

    logic apply;
    logic pin_next;

    assign apply = fire && en && (mode != EDGE_NONE);

    // Level produced by the selected action
    always_comb begin
        case (mode)
            EDGE_RISE:   pin_next = 1'b1;
            EDGE_FALL:   pin_next = 1'b0;
            EDGE_TOGGLE: pin_next = !pin_q;
            default:     pin_next = pin_q;
        endcase
    end

    // Pin level register
    always_ff @(posedge clk) begin
        if (!rst_n)     pin_q <= 1'b0;
        else if (apply) pin_q <= pin_next;
    end

    // Event counter, one step per applied action
    always_ff @(posedge clk) begin
        if (!rst_n)     evt_q <= '0;
        else if (apply) evt_q <= evt_q + 1'b1;
    end

endmodule

// File: rtl/timed_pulse_gen.sv
// Module: top of the timed compare pulse output.
// Joins the register front end, the compare/arm logic and the pin driver.
// Assumes time_now is already in the clk domain and advances by one per
// clock in normal use. The compare is two data words wide.
module timed_pulse_gen
    import tpg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DELAY  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] time_now,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                pin_out,
    output logic                pin_oe
);

    localparam int TIME_W = 2 * DATA_W;

    ctrl_t             ctrl_w;
    logic              en_w;
    logic              load_stb_w;
    logic [TIME_W-1:0] load_val_w;
    logic [TIME_W-1:0] cmp_w;
    logic              armed_w;
    logic              hit_w;
    logic              fire_w;
    logic [DATA_W-1:0] evt_w;

    assign en_w   = ctrl_w.en;
    assign pin_oe = !ctrl_w.dir_in;

    tpg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .cmp_q     (cmp_w),
        .evt_count (evt_w),
        .ctrl_q    (ctrl_w),
        .load_stb  (load_stb_w),
        .load_val  (load_val_w)
    );

    tpg_match #(
        .TIME_W (TIME_W),
        .DELAY  (DELAY)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .time_now (time_now),
        .load_stb (load_stb_w),
        .load_val (load_val_w),
        .cmp_q    (cmp_w),
        .armed_q  (armed_w),
        .hit_q    (hit_w),
        .fire     (fire_w)
    );

    tpg_pin #(
        .CNT_W (DATA_W)
    ) u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_w),
        .fire  (fire_w),
        .mode  (ctrl_w.mode),
        .pin_q (pin_out),
        .evt_q (evt_w)
    );

endmodule

// File: rtl/tpg_checker.sv
// Module: property checker, bound to timed_pulse_gen.
// Watches the enable, the pin, the event count, the arm state and the bus
// response. It only observes and drives nothing.
module tpg_checker #(
    parameter int DATA_W = 32,
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              pin_out,
    input logic [DATA_W-1:0] evt_count,
    input logic              armed,
    input logic [TIME_W-1:0] cmp_q,
    input logic              hit_q,
    input logic              load_stb,
    input logic              req_valid,
    input logic              req_write,
    input logic              rsp_valid
);

    // R5: an armed state never holds a zero compare value
    p_zero_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cmp_q != '0));

    // R7: the event count moves by at most one per clock
    p_evt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_count == $past(evt_count)) || (evt_count == $past(evt_count) + 1'b1));

    // R8: with the enable clear, the pin level is frozen
    p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> $stable(pin_out));

    // R8: with the enable clear, the event count is frozen
    p_evt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> $stable(evt_count));

    // R9: a match leaves the block disarmed unless a reload came on the same edge
    p_fire_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && !$past(load_stb)) |-> !armed);

    // R10: every read request is answered on the next clock
    p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

bind timed_pulse_gen tpg_checker #(
    .DATA_W (DATA_W),
    .TIME_W (2 * DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_w),
    .pin_out   (pin_out),
    .evt_count (evt_w),
    .armed     (armed_w),
    .cmp_q     (cmp_w),
    .hit_q     (hit_w),
    .load_stb  (load_stb_w),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_timed_pulse_gen.sv
`timescale 1ns/1ps
module tb_timed_pulse_gen;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_LO   = 8'h10;
    localparam logic [7:0] A_HI   = 8'h14;
    localparam logic [7:0] A_EVT  = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tnow;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        pin_out;
    logic        pin_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = !clk;

    // Free-running time base seen by the block
    always_ff @(posedge clk) begin
        if (!rst_n) tnow <= 64'd5;
        else        tnow <= tnow + 64'd1;
    end

    timed_pulse_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .time_now  (tnow),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Write: driven after a falling edge, taken on the next rising edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Read: the response must be valid one clock after the request (R10)
    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1 && req_ready === 1'b1, "R10 response timing", {62'd0, req_ready, rsp_valid}, 64'd3);
        d = rsp_rdata;
    endtask

    // Watch the pin for a number of clocks; report the first change time and the change count
    task automatic watch(input int cycles, input logic p0, output int changes, output logic [63:0] tchg);
        logic last;
        last = p0; changes = 0; tchg = '0;
        for (int k = 0; k < cycles; k++) begin
            if (pin_out !== last) begin
                if (changes == 0) tchg = tnow;
                changes++;
                last = pin_out;
            end
            @(negedge clk);
        end
    endtask

    // One sweep point: edge action 'mode' with a target of the given kind
    task automatic run_case(input int mode, input int kind);
        logic [31:0] e0, e1;
        logic [63:0] t0, cval, tw, s, tchg;
        logic        p0, pexp;
        int          changes;
        bus_wr(A_CTRL, 32'(mode << 2) | 32'd1);
        bus_rd(A_EVT, e0);
        p0 = pin_out;
        t0 = tnow;
        cval = (kind == 0) ? 64'd1 : t0 + 64'(kind * 7);
        bus_wr(A_HI, cval[63:32]);
        bus_wr(A_LO, cval[31:0]);
        tw = tnow;
        case (mode)
            0: pexp = 1'b1;
            1: pexp = 1'b0;
            2: pexp = !p0;
            default: pexp = p0;
        endcase
        s = (cval > tw) ? cval : tw;
        watch(60, p0, changes, tchg);
        if (pexp != p0) begin
            chk(changes > 0 && tchg == s + 64'd3, "R6 edge time", tchg, s + 64'd3);
        end
        chk(pin_out == pexp, "R7 pin level after action", {63'd0, pin_out}, {63'd0, pexp});
        chk(changes == ((pexp != p0) ? 1 : 0), "R9 single edge per arming", 64'(changes), 64'((pexp != p0) ? 1 : 0));
        bus_rd(A_EVT, e1);
        chk(e1 == e0 + ((mode != 3) ? 32'd1 : 32'd0), "R7 event count step", {32'd0, e1}, {32'd0, e0 + ((mode != 3) ? 32'd1 : 32'd0)});
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, e0, e1;
        logic [63:0] t0, cval, tw, tchg;
        logic        p0;
        int          changes;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(pin_out == 1'b0, "R1 pin low", {63'd0, pin_out}, 64'd0);
        chk(pin_oe == 1'b1, "R1 output enable", {63'd0, pin_oe}, 64'd1);
        bus_rd(A_CTRL, d); chk(d == 0, "R1 control", {32'd0, d}, 0);
        bus_rd(A_LO, d);   chk(d == 0, "R1 compare low", {32'd0, d}, 0);
        bus_rd(A_HI, d);   chk(d == 0, "R1 compare high", {32'd0, d}, 0);
        bus_rd(A_EVT, d);  chk(d == 0, "R1 event count", {32'd0, d}, 0);

        // R2 and R3: control field layout, reserved bits and direction
        bus_wr(A_CTRL, 32'hFFFF_FFFE);
        bus_rd(A_CTRL, d); chk(d == 32'hE, "R2 control reserved bits", {32'd0, d}, 64'hE);
        chk(pin_oe == 1'b0, "R3 direction input", {63'd0, pin_oe}, 64'd0);
        bus_wr(A_CTRL, 32'h0);
        chk(pin_oe == 1'b1, "R3 direction output", {63'd0, pin_oe}, 64'd1);
        bus_rd(8'h20, d); chk(d == 0, "R2 unmapped offset", {32'd0, d}, 0);

        // R10: writing the event count has no effect
        bus_wr(A_EVT, 32'h1234);
        bus_rd(A_EVT, d); chk(d == 0, "R10 event count read-only", {32'd0, d}, 0);

        // R5: a zero compare never fires
        bus_wr(A_CTRL, 32'h9);
        bus_rd(A_EVT, e0);
        p0 = pin_out;
        bus_wr(A_HI, 32'h0);
        bus_wr(A_LO, 32'h0);
        watch(30, p0, changes, tchg);
        chk(changes == 0, "R5 no edge for zero compare", 64'(changes), 0);
        bus_rd(A_EVT, e1); chk(e1 == e0, "R5 no count for zero compare", {32'd0, e1}, {32'd0, e0});

        // R6, R7, R9: sweep every action against past, near and later targets
        for (int kind = 0; kind < 4; kind++) begin
            for (int mode = 0; mode < 4; mode++) begin
                run_case(mode, kind);
            end
        end

        // R4: a staged high word does not disturb the armed compare
        bus_wr(A_CTRL, 32'h9);
        p0 = pin_out;
        t0 = tnow;
        cval = t0 + 64'd30;
        bus_wr(A_HI, cval[63:32]);
        bus_wr(A_LO, cval[31:0]);
        bus_wr(A_HI, 32'h1);
        bus_rd(A_HI, d); chk(d == cval[63:32], "R4 high word not yet active", {32'd0, d}, {32'd0, cval[63:32]});
        watch(40, p0, changes, tchg);
        chk(changes == 1 && tchg == cval + 64'd3, "R4 old compare still fires", tchg, cval + 64'd3);
        bus_wr(A_LO, 32'h5);
        bus_rd(A_HI, d); chk(d == 32'h1, "R4 low write loads staged high", {32'd0, d}, 64'h1);
        bus_rd(A_LO, d); chk(d == 32'h5, "R4 low word active", {32'd0, d}, 64'h5);
        bus_wr(A_HI, 32'h0);
        bus_wr(A_LO, 32'h0);

        // R8: disable holds everything; re-enable fires the pending target
        bus_wr(A_CTRL, 32'h9);
        bus_rd(A_EVT, e0);
        p0 = pin_out;
        t0 = tnow;
        cval = t0 + 64'd20;
        bus_wr(A_HI, cval[63:32]);
        bus_wr(A_LO, cval[31:0]);
        bus_wr(A_CTRL, 32'h8);
        watch(40, p0, changes, tchg);
        chk(changes == 0, "R8 pin held while disabled", 64'(changes), 0);
        bus_rd(A_EVT, e1); chk(e1 == e0, "R8 count held while disabled", {32'd0, e1}, {32'd0, e0});
        bus_wr(A_CTRL, 32'h9);
        tw = tnow;
        watch(20, p0, changes, tchg);
        chk(changes == 1 && tchg == tw + 64'd3, "R8 pending target fires on re-enable", tchg, tw + 64'd3);
        bus_rd(A_EVT, e1); chk(e1 == e0 + 1, "R8 count after re-enable", {32'd0, e1}, {32'd0, e0 + 32'd1});

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule